// File: doc/BRIEF.md
# Page-Write Address and Pointer Unit

This block keeps the internal address pointer for one port of a serial EEPROM. The serial engine sends it single-cycle events: a word address has been loaded, a data byte was accepted, a read byte went out, or a stop condition arrived. From these events the unit works out where the next byte goes or comes from. Writes are collected in a 16-slot page latch with a valid bit per slot. When a stop condition ends a write, the unit hands the page base and the valid mask to the array controller, which reads the data through a slot-select port.

The address space follows a space selector. Bank space is 256 bytes. Combined space is 512 bytes, and in it an extra high bit picks the half. Configuration space is 16 bytes. During a write burst only the in-page offset moves. On reads the pointer rolls over at the top of the selected space.

Top module: `pgptr_unit`

## Requirements
- R1: After a synchronous active-high reset, `cur_addr_o` is 0, `page_mask_o` is 0, `commit_o` is low, and no write burst is open.
- R2: A pulse on `ld_addr_i` sets the pointer according to `space_i`. Code 2'b00 (and the unused 2'b11) selects bank space, where the pointer becomes {0, word}. Code 2'b01 selects combined space, where it becomes {hi_bit_i, word}. Code 2'b10 selects configuration space, where it becomes word bits 3..0 with zeros above. The same pulse clears the page mask and opens a write burst.
- R3: Each `wr_byte_i` pulse inside an open burst stores `wr_data_i` in slot `cur_addr_o[3:0]` and sets that slot's mask bit. It then increments address bits 3..0 modulo 16 and leaves bits 8..4 unchanged.
- R4: If a slot is written more than once in a burst, reading that slot through `slot_sel_i`/`slot_data_o` returns the byte received last.
- R5: A `stop_i` pulse during an open burst with a non-zero mask raises `commit_o` for exactly one cycle after that clock edge. At the same time it presents `commit_base_o` (the pointer with bits 3..0 cleared) and `commit_mask_o` (the mask). A stop with an empty mask, or with no open burst, raises nothing. A stop always closes the burst.
- R6: After a burst of N bytes, the pointer equals the start address plus N, taken modulo 16 within the page. A single byte written at offset 4'hF therefore leaves the pointer at offset 4'h0 of the same page.
- R7: Each `rd_byte_i` pulse in bank space advances the pointer by one modulo 256, so 0FFh goes to 000h and bit 8 stays 0.
- R8: In combined space, `rd_byte_i` advances the pointer modulo 512, so 0FFh goes to 100h and 1FFh goes to 000h.
- R9: In configuration space, `rd_byte_i` advances the pointer modulo 16, so 0Fh goes to 00h.
- R10: `wr_byte_i` has no effect on the pointer, the mask or the slot contents when no burst is open: before the first load, after a stop, or after a read byte, since `rd_byte_i` closes the burst.
- R11: When several event inputs pulse in the same cycle, `ld_addr_i` wins over `wr_byte_i`, which wins over `rd_byte_i`, which wins over `stop_i`. The losing events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| space_i | input | 2 | Address-space select: 00 bank, 01 combined, 10 configuration |
| hi_bit_i | input | 1 | Half select used by a load in combined space |
| ld_addr_i | input | 1 | Word address received (one-cycle pulse) |
| word_addr_i | input | 8 | Received word address |
| wr_byte_i | input | 1 | Data byte accepted (one-cycle pulse) |
| wr_data_i | input | 8 | Accepted data byte |
| rd_byte_i | input | 1 | Read byte sent (one-cycle pulse) |
| stop_i | input | 1 | Stop condition received (one-cycle pulse) |
| slot_sel_i | input | 4 | Page-latch slot to read out |
| slot_data_o | output | 8 | Contents of the selected slot |
| cur_addr_o | output | 9 | Current internal pointer |
| page_mask_o | output | 16 | Per-slot valid mask of the open page |
| commit_o | output | 1 | One-cycle pulse: page ready to program |
| commit_base_o | output | 9 | Page base address of the commit |
| commit_mask_o | output | 16 | Slots to program in the commit |

## Verification
The bench uses the default parameters: an 8-bit bank address, 4-bit page offset and 8-bit data. With these, every wrap boundary is a few pulses away. A read can start at FEh, 0FFh or 1FFh and cross the boundary in two steps. A 20-byte burst laps the 16-slot page, so the same slots are overwritten and the pointer comes back to start plus four. The configuration space is only 16 bytes deep, so its rollover needs just two reads from a loaded offset of Eh.

// File: rtl/pgptr_pkg.sv
package pgptr_pkg;

    localparam int BANK_AW = 8;
    localparam int PG_AW   = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = BANK_AW + 1;
    localparam int PG_N    = 1 << PG_AW;

    typedef enum logic [1:0] {
        SP_BANK = 2'b00,
        SP_COMB = 2'b01,
        SP_CFG  = 2'b10
    } space_e;

    typedef struct packed {
        logic              go;
        logic [ADDR_W-1:0] base;
        logic [PG_N-1:0]   mask;
    } commit_t;

    function automatic space_e space_of(input logic [1:0] code);
        case (code)
            2'b01:   return SP_COMB;
            2'b10:   return SP_CFG;
            default: return SP_BANK;
        endcase
    endfunction

endpackage

// File: rtl/pgptr_addr.sv
module pgptr_addr
    import pgptr_pkg::*;
#(
    parameter int BA_W = BANK_AW,
    parameter int PO_W = PG_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  space_e          space_i,
    input  logic            hi_i,
    input  logic            ld_i,
    input  logic [BA_W-1:0] wa_i,
    input  logic            wstep_i,
    input  logic            rstep_i,
    output logic [BA_W:0]   ptr_o
);
    localparam int AW = BA_W + 1;

    logic [AW-1:0]   ptr_q;
    logic [AW-1:0]   load_val;
    logic [AW-1:0]   seq_next;
    logic [PO_W-1:0] off_nx;
    logic [BA_W-1:0] bank_nx;

    assign off_nx  = ptr_q[PO_W-1:0] + PO_W'(1);
    assign bank_nx = ptr_q[BA_W-1:0] + BA_W'(1);

    always_comb begin
        case (space_i)
            SP_COMB: load_val = {hi_i, wa_i};
            SP_CFG:  load_val = AW'(wa_i[PO_W-1:0]);
            default: load_val = {1'b0, wa_i};
        endcase
    end

    always_comb begin
        case (space_i)
            SP_COMB: seq_next = ptr_q + AW'(1);
            SP_CFG:  seq_next = AW'(off_nx);
            default: seq_next = {1'b0, bank_nx};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (ld_i)
            ptr_q <= load_val;
        else if (wstep_i)
            ptr_q <= {ptr_q[AW-1:PO_W], off_nx};
        else if (rstep_i)
            ptr_q <= seq_next;
    end

    assign ptr_o = ptr_q;

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wstep_i && !ld_i |=> ptr_q[AW-1:PO_W] == $past(ptr_q[AW-1:PO_W]));

    // R7
    bank_top_chk: assert property (@(posedge clk) disable iff (rst)
        rstep_i && !ld_i && !wstep_i && space_i == SP_BANK |=> ptr_q[AW-1] == 1'b0);

    // R9
    cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
        rstep_i && !ld_i && !wstep_i && space_i == SP_CFG |=> ptr_q[AW-1:PO_W] == '0);

endmodule

// File: rtl/pgptr_latch.sv
module pgptr_latch
    import pgptr_pkg::*;
#(
    parameter int PO_W = PG_AW,
    parameter int DW   = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [PO_W-1:0]   off_i,
    input  logic [DW-1:0]     data_i,
    input  logic [PO_W-1:0]   rd_idx_i,
    output logic [DW-1:0]     rd_data_o,
    output logic [(1<<PO_W)-1:0] mask_o
);
    localparam int NS = 1 << PO_W;

    logic [DW-1:0] mem_q [NS];
    logic [NS-1:0] vld_q;

    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (rst) begin
                vld_q[s] <= 1'b0;
            end else if (clr_i) begin
                vld_q[s] <= 1'b0;
            end else if (we_i && off_i == PO_W'(s)) begin
                vld_q[s] <= 1'b1;
                mem_q[s] <= data_i;
            end
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
    assign mask_o    = vld_q;

    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> vld_q == '0);

    // R3
    mask_grow_chk: assert property (@(posedge clk) disable iff (rst)
        we_i && !clr_i |=> $countones(vld_q) >= $countones($past(vld_q)));

endmodule

// File: rtl/pgptr_commit.sv
module pgptr_commit
    import pgptr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PO_W = PG_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_i,
    input  logic                 wstep_i,
    input  logic                 rstep_i,
    input  logic                 stop_i,
    input  logic [(1<<PO_W)-1:0] mask_i,
    input  logic [AW-1:0]        ptr_i,
    output logic                 active_o,
    output commit_t              commit_o
);
    logic    active_q;
    logic    stop_eff;
    commit_t cmt_q;

    assign stop_eff = stop_i && !ld_i && !wstep_i && !rstep_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cmt_q    <= '0;
        end else begin
            cmt_q.go <= 1'b0;
            if (ld_i) begin
                active_q <= 1'b1;
            end else if (rstep_i) begin
                active_q <= 1'b0;
            end else if (stop_eff) begin
                active_q <= 1'b0;
                if (active_q && |mask_i) begin
                    cmt_q.go   <= 1'b1;
                    cmt_q.base <= {ptr_i[AW-1:PO_W], PO_W'(0)};
                    cmt_q.mask <= mask_i;
                end
            end
        end
    end

    assign active_o = active_q;
    assign commit_o = cmt_q;

    // R5
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_q.go |=> !cmt_q.go);

    // R5
    commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_q.go |-> $past(stop_i) && cmt_q.mask != '0);

    // R10
    read_close_chk: assert property (@(posedge clk) disable iff (rst)
        rstep_i && !ld_i |=> !active_q);

endmodule

// File: rtl/pgptr_unit.sv
module pgptr_unit
    import pgptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        space_i,
    input  logic              hi_bit_i,
    input  logic              ld_addr_i,
    input  logic [BANK_AW-1:0] word_addr_i,
    input  logic              wr_byte_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_byte_i,
    input  logic              stop_i,
    input  logic [PG_AW-1:0]  slot_sel_i,
    output logic [DATA_W-1:0] slot_data_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [PG_N-1:0]   page_mask_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] commit_base_o,
    output logic [PG_N-1:0]   commit_mask_o
);
    space_e            space;
    logic              active;
    logic              wstep;
    logic              rstep;
    logic [ADDR_W-1:0] ptr;
    logic [PG_N-1:0]   mask;
    commit_t           cmt;

    assign space = space_of(space_i);
    assign wstep = wr_byte_i && active && !ld_addr_i;
    assign rstep = rd_byte_i && !ld_addr_i && !wstep;

    pgptr_addr #(.BA_W(BANK_AW), .PO_W(PG_AW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .space_i (space),
        .hi_i    (hi_bit_i),
        .ld_i    (ld_addr_i),
        .wa_i    (word_addr_i),
        .wstep_i (wstep),
        .rstep_i (rstep),
        .ptr_o   (ptr)
    );

    pgptr_latch #(.PO_W(PG_AW), .DW(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (ld_addr_i),
        .we_i      (wstep),
        .off_i     (ptr[PG_AW-1:0]),
        .data_i    (wr_data_i),
        .rd_idx_i  (slot_sel_i),
        .rd_data_o (slot_data_o),
        .mask_o    (mask)
    );

    pgptr_commit #(.AW(ADDR_W), .PO_W(PG_AW)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .ld_i     (ld_addr_i),
        .wstep_i  (wstep),
        .rstep_i  (rstep),
        .stop_i   (stop_i),
        .mask_i   (mask),
        .ptr_i    (ptr),
        .active_o (active),
        .commit_o (cmt)
    );

    assign cur_addr_o    = ptr;
    assign page_mask_o   = mask;
    assign commit_o      = cmt.go;
    assign commit_base_o = cmt.base;
    assign commit_mask_o = cmt.mask;

    // R10
    idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_byte_i && !active && !ld_addr_i && !rd_byte_i |=> cur_addr_o == $past(cur_addr_o) && page_mask_o == $past(page_mask_o));

endmodule

// File: tb/test_pgptr_unit.sv
`timescale 1ns/1ps
module test_pgptr_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  space_i = 2'b00;
    logic        hi_bit_i = 1'b0;
    logic        ld_addr_i = 1'b0;
    logic [7:0]  word_addr_i = '0;
    logic        wr_byte_i = 1'b0;
    logic [7:0]  wr_data_i = '0;
    logic        rd_byte_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [3:0]  slot_sel_i = '0;
    logic [7:0]  slot_data_o;
    logic [8:0]  cur_addr_o;
    logic [15:0] page_mask_o;
    logic        commit_o;
    logic [8:0]  commit_base_o;
    logic [15:0] commit_mask_o;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    int ref_ptr = 0;
    int ref_mask = 0;
    bit ref_act = 0;
    bit ref_go = 0;
    int ref_base = 0;
    int ref_cmask = 0;
    int ref_lat [16];

    always #(CLK_P/2) clk = ~clk;

    pgptr_unit i_pgptr_unit (
        .clk(clk), .rst(rst), .space_i(space_i), .hi_bit_i(hi_bit_i),
        .ld_addr_i(ld_addr_i), .word_addr_i(word_addr_i), .wr_byte_i(wr_byte_i),
        .wr_data_i(wr_data_i), .rd_byte_i(rd_byte_i), .stop_i(stop_i),
        .slot_sel_i(slot_sel_i), .slot_data_o(slot_data_o), .cur_addr_o(cur_addr_o),
        .page_mask_o(page_mask_o), .commit_o(commit_o), .commit_base_o(commit_base_o),
        .commit_mask_o(commit_mask_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference, updated at each rising edge from the held inputs.
    always @(posedge clk) begin
        int off;
        if (rst) begin
            ref_ptr = 0; ref_mask = 0; ref_act = 0; ref_go = 0;
        end else begin
            ref_go = 0;
            if (ld_addr_i) begin
                if (space_i == 2'b01)      ref_ptr = hi_bit_i * 256 + word_addr_i;
                else if (space_i == 2'b10) ref_ptr = word_addr_i % 16;
                else                       ref_ptr = word_addr_i;
                ref_mask = 0;
                ref_act = 1;
            end else if (wr_byte_i && ref_act) begin
                off = ref_ptr % 16;
                ref_lat[off] = wr_data_i;
                ref_mask = ref_mask | (1 << off);
                ref_ptr = (ref_ptr / 16) * 16 + (off + 1) % 16;
            end else if (rd_byte_i) begin
                ref_act = 0;
                if (space_i == 2'b01)      ref_ptr = (ref_ptr + 1) % 512;
                else if (space_i == 2'b10) ref_ptr = (ref_ptr % 16 + 1) % 16;
                else                       ref_ptr = (ref_ptr % 256 + 1) % 256;
            end else if (stop_i) begin
                if (ref_act && ref_mask != 0) begin
                    ref_go = 1;
                    ref_cmask = ref_mask;
                    ref_base = (ref_ptr / 16) * 16;
                end
                ref_act = 0;
            end
        end
        #2;
        check(cur_req, "pointer", int'(cur_addr_o), ref_ptr);
        check(cur_req, "mask", int'(page_mask_o), ref_mask);
        check(cur_req, "commit", int'(commit_o), int'(ref_go));
        if (ref_go) begin
            check(cur_req, "commit base", int'(commit_base_o), ref_base);
            check(cur_req, "commit mask", int'(commit_mask_o), ref_cmask);
        end
    end

    task automatic cyc(input bit l, input int wa, input bit w, input int d, input bit r, input bit s);
        @(negedge clk);
        ld_addr_i = l; word_addr_i = 8'(wa); wr_byte_i = w;
        wr_data_i = 8'(d); rd_byte_i = r; stop_i = s;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic set_space(input int sp, input bit hi);
        @(negedge clk);
        space_i = 2'(sp); hi_bit_i = hi;
    endtask

    task automatic check_latch(input string req);
        idle();
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            slot_sel_i = 4'(i);
            #0.2;
            if ((ref_mask >> i) & 1)
                check(req, "slot data", int'(slot_data_o), ref_lat[i]);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "reset pointer", int'(cur_addr_o), 0);
        check("R1", "reset mask", int'(page_mask_o), 0);
        check("R1", "reset commit", int'(commit_o), 0);

        // R10 write before any load is ignored
        cur_req = "R10";
        cyc(0, 0, 1, 8'h11, 0, 0); idle();

        // R2 R3 R5 R6 bank byte burst of three
        cur_req = "R3";
        cyc(1, 8'h35, 0, 0, 0, 0);
        cyc(0, 0, 1, 8'hA1, 0, 0);
        cyc(0, 0, 1, 8'hA2, 0, 0);
        cyc(0, 0, 1, 8'hA3, 0, 0);
        cur_req = "R5";
        cyc(0, 0, 0, 0, 0, 1); idle(); idle();
        check("R6", "ptr after 3 bytes", int'(cur_addr_o), 9'h038);
        check_latch("R3");

        // R6 single byte at offset F wraps to 0
        cur_req = "R6";
        cyc(1, 8'h3F, 0, 0, 0, 0);
        cyc(0, 0, 1, 8'h5C, 0, 0);
        cyc(0, 0, 0, 0, 0, 1); idle();
        check("R6", "byte at F", int'(cur_addr_o), 9'h030);

        // R4 twenty bytes lap the page
        cur_req = "R4";
        cyc(1, 8'h20, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, 8'h40 + i, 0, 0);
        check_latch("R4");
        cyc(0, 0, 0, 0, 0, 1); idle();
        check("R6", "ptr after 20 bytes", int'(cur_addr_o), 9'h024);

        // R5 stop with empty mask, then repeated stop
        cur_req = "R5";
        cyc(1, 8'h50, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1); idle();

        // R10 write after stop is ignored
        cur_req = "R10";
        cyc(0, 0, 1, 8'hEE, 0, 0); idle();

        // R7 bank read rollover
        cur_req = "R7";
        cyc(1, 8'hFE, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0); idle();
        check("R7", "bank read wrap", int'(cur_addr_o), 9'h001);

        // R8 combined crossing and rollover
        cur_req = "R8";
        set_space(1, 0);
        cyc(1, 8'hFE, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0); idle();
        check("R8", "combined 0FF to 100", int'(cur_addr_o), 9'h100);
        set_space(1, 1);
        cyc(1, 8'hFF, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0); idle();
        check("R8", "combined 1FF to 000", int'(cur_addr_o), 9'h000);

        // R3 combined page burst in upper half
        cur_req = "R3";
        cyc(1, 8'hF8, 0, 0, 0, 0);
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 8'h70 + i, 0, 0);
        cyc(0, 0, 0, 0, 0, 1); idle();
        check("R3", "upper page ptr", int'(cur_addr_o), 9'h1F2);

        // R9 configuration space
        cur_req = "R9";
        set_space(2, 1);
        cyc(1, 8'hAE, 0, 0, 0, 0); idle();
        check("R2", "config load", int'(cur_addr_o), 9'h00E);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0); idle();
        check("R9", "config wrap", int'(cur_addr_o), 9'h000);

        // R10 a read byte closes the burst
        cur_req = "R10";
        set_space(3, 0);
        cyc(1, 8'h80, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 1, 8'h99, 0, 0);
        cyc(0, 0, 0, 0, 0, 1); idle();
        check("R10", "mask after read", int'(page_mask_o), 0);

        // R11 priority of simultaneous events
        cur_req = "R11";
        set_space(0, 0);
        cyc(1, 8'h10, 1, 8'h33, 1, 1); idle();
        check("R11", "load wins", int'(cur_addr_o), 9'h010);
        cyc(0, 0, 1, 8'h44, 1, 1); idle();
        check("R11", "write over read", int'(cur_addr_o), 9'h011);
        cyc(0, 0, 0, 0, 1, 1); idle();
        check("R11", "read over stop", int'(commit_o), 0);
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule